// File: doc/BRIEF.md
# Sequential SPI Boot Byte Streamer

This block lets an 8-bit CPU boot from a small serial EEPROM without an address path to it. Once reset is released it selects the EEPROM, clocks out a fixed read preamble on the SPI lines, and then waits. Each CPU read in the upper half of the address space (the boot window) pulls exactly eight more bits from the EEPROM. The block assembles them into a byte and hands it to the CPU. The address the CPU presents only decides whether the block is selected. The bytes come out strictly in order, so the first two reads (the reset vector fetch) get the first two bytes of the image.

The CPU read uses a valid/ready handshake. The CPU raises `rd_valid` with a stable address and holds both until it sees `rd_ready`. The transfer completes on the clock edge where both are high. While `rd_ready` is low the CPU clock logic stretches the cycle. The block applies back-pressure for the whole time the eight bits are shifting. When the CPU fetches an opcode from below the window, execution has moved to RAM. The block then releases chip select and stays silent until the next reset.

Top module: `spi_boot_streamer`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sclk` is 0, `rd_ready` and `rd_drive` are 0, and `rd_data` is 0.
- R2: After reset, `spi_cs_n` goes low and PRE_CLKS (default 8) SPI clock pulses are sent. `spi_mosi` is 1 at the first two rising `spi_sclk` edges and 0 at every later one. Bits on `spi_miso` during these pulses are discarded.
- R3: `spi_sclk` stays low while no boot-window read is waiting for data.
- R4: Each boot-window read produces exactly 8 rising `spi_sclk` edges. `spi_miso` is sampled on each rising edge, and the first bit sampled becomes the byte's bit 7 (MSB first). Starting from reset, the first two bytes returned are image bytes 0 and 1.
- R5: A boot-window read that starts while the SPI link is idle sees `rd_ready` go high exactly 17 clock cycles after `rd_valid` is first sampled. `rd_ready` stays low until then. It drops in the cycle after a completed transfer.
- R6: The address bits do not affect the data. Any address at or above WIN_BASE (0x8000) receives the next byte of the image in sequence.
- R7: `rd_drive` is high, and `rd_data` is non-zero-capable, only while `rd_ready` is high for a boot-window read. At all other times `rd_drive` is 0 and `rd_data` is 0.
- R8: A read below WIN_BASE with `rd_fetch` low is ignored: no ready, no drive, no SPI clocks, and the next window read still returns the next image byte.
- R9: A read below WIN_BASE with `rd_fetch` high switches the block to runtime mode from the next cycle on. `spi_cs_n` is then 1, and window reads get no ready, no drive and no SPI clocks until reset.
- R10: A new reset restarts the stream, so the next two reads return image bytes 0 and 1 again.
- R11: A window read issued while the preamble is still running waits for the preamble to finish and then returns image byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one SPI bit spans two cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | CPU read request, held until `rd_ready` |
| rd_addr | input | 16 | CPU address, used only for window decode |
| rd_fetch | input | 1 | High when the read is an opcode fetch |
| rd_ready | output | 1 | Byte available; low means stretch the CPU cycle |
| rd_data | output | 8 | Byte for the CPU, zero when not driving |
| rd_drive | output | 1 | Enable for the data bus pad driver |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the EEPROM (preamble pattern) |
| spi_miso | input | 1 | SPI data from the EEPROM |

## Verification
The assertions assume that the CPU keeps to the handshake: once `rd_valid` is raised for a window read, it stays high with an unchanged address until `rd_ready` has been seen. They also assume that runtime mode is entered only through a fetch below the window. The bench drives every request from a task that holds `rd_valid` and the address stable until ready, or for a fixed number of cycles for reads the block must ignore. It changes inputs only on falling clock edges. The EEPROM model is the one in the bench. It counts rising SPI clock edges within a chip-select session and returns junk for the first eight, so the check of MSB-first assembly uses a known pattern.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    SH_INIT,
    SH_PRE,
    SH_IDLE,
    SH_SHIFT,
    SH_OFF
  } shf_state_e;
endpackage

// File: rtl/spi_boot_shifter.sv
module spi_boot_shifter
  import spi_boot_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PRE_CLKS     = 8,
  parameter int MOSI_HI_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_req,
  input  logic              stop,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int MAXC  = (PRE_CLKS > DATA_W) ? PRE_CLKS : DATA_W;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CLKS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] MOSI_HI   = CNT_W'(MOSI_HI_CLKS);

  shf_state_e        state_q;
  logic              ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sreg_q;
  logic              last_clk;

  assign last_clk = (state_q == SH_PRE) ? (cnt_q == PRE_LAST) : (cnt_q == BYTE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SH_INIT;
      ph_q    <= 1'b0;
      cnt_q   <= '0;
      sreg_q  <= '0;
    end else if (stop) begin
      state_q <= SH_OFF;
      ph_q    <= 1'b0;
    end else begin
      case (state_q)
        SH_INIT: begin
          state_q <= SH_PRE;
          cnt_q   <= '0;
        end
        SH_PRE, SH_SHIFT: begin
          if (!ph_q) begin
            ph_q <= 1'b1;
            if (state_q == SH_SHIFT) sreg_q <= {sreg_q[DATA_W-2:0], miso};
          end else begin
            ph_q <= 1'b0;
            if (last_clk) begin
              cnt_q   <= '0;
              state_q <= SH_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SH_IDLE: begin
          if (byte_req) begin
            state_q <= SH_SHIFT;
            cnt_q   <= '0;
          end
        end
        default: state_q <= SH_OFF;
      endcase
    end
  end

  assign sclk      = ph_q;
  assign cs_n      = (state_q == SH_INIT) || (state_q == SH_OFF);
  assign mosi      = (state_q == SH_PRE) && (cnt_q < MOSI_HI);
  assign byte_done = (state_q == SH_SHIFT) && ph_q && last_clk;
  assign byte_val  = sreg_q;
endmodule

// File: rtl/boot_window_ctl.sv
module boot_window_ctl #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned WIN_BASE = 32'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_fetch,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  output logic              byte_req,
  output logic              stop,
  output logic              rd_ready,
  output logic              rd_drive,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  logic              boot_q;
  logic              have_q;
  logic [DATA_W-1:0] data_q;
  logic              in_win;
  logic              sel;

  assign in_win   = (rd_addr >= BASE);
  assign sel      = boot_q && rd_valid && in_win;
  assign stop     = boot_q && rd_valid && rd_fetch && !in_win;
  assign byte_req = sel && !have_q;
  assign rd_ready = sel && have_q;
  assign rd_drive = rd_ready;
  assign rd_data  = rd_ready ? data_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      have_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (stop) boot_q <= 1'b0;
      if (byte_done) begin
        have_q <= 1'b1;
        data_q <= byte_val;
      end else if (rd_ready) begin
        have_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_boot_streamer.sv
module spi_boot_streamer #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned WIN_BASE = 32'h8000,
  parameter int          PRE_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_fetch,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              byte_req;
  logic              stop;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;

  spi_boot_shifter #(
    .DATA_W      (DATA_W),
    .PRE_CLKS    (PRE_CLKS),
    .MOSI_HI_CLKS(2)
  ) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_req (byte_req),
    .stop     (stop),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  boot_window_ctl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WIN_BASE(WIN_BASE)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_fetch (rd_fetch),
    .byte_done(byte_done),
    .byte_val (byte_val),
    .byte_req (byte_req),
    .stop     (stop),
    .rd_ready (rd_ready),
    .rd_drive (rd_drive),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/spi_boot_streamer_chk.sv
module spi_boot_streamer_chk #(
  parameter int          ADDR_W   = 16,
  parameter int unsigned WIN_BASE = 32'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_fetch,
  input logic              rd_ready,
  input logic              rd_drive,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_mosi
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  logic went_ram_q;
  always_ff @(posedge clk) begin
    if (!rst_n) went_ram_q <= 1'b0;
    else if (rd_valid && rd_fetch && (rd_addr < BASE)) went_ram_q <= 1'b1;
  end

  AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_valid && rd_addr >= BASE)); // R5
  AST_READY_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_ready); // R5
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (rd_valid && rd_addr >= BASE && rd_ready)); // R7
  AST_NO_SCLK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R9
  AST_RUNTIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    went_ram_q |-> (spi_cs_n && !rd_ready && !rd_drive)); // R9
  AST_SCLK_IDLE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !spi_sclk); // R3
  AST_MOSI_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mosi |-> !spi_cs_n); // R2
endmodule

bind spi_boot_streamer spi_boot_streamer_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_valid(rd_valid),
  .rd_addr (rd_addr),
  .rd_fetch(rd_fetch),
  .rd_ready(rd_ready),
  .rd_drive(rd_drive),
  .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi)
);

// File: tb/sim_spi_boot_streamer.sv
`timescale 1ns/1ps
module sim_spi_boot_streamer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = 16'h0000;
  logic        rd_fetch = 1'b0;
  logic        rd_ready;
  logic [7:0]  rd_data;
  logic        rd_drive;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  int sess = 0;
  int mosi_bad = 0;

  always #2 clk = ~clk;

  spi_boot_streamer u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_fetch(rd_fetch), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_drive(rd_drive), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] img(int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'h80;
    return 8'(i * 37 + 11);
  endfunction

  // EEPROM model: junk during preamble, then image bits MSB first
  always @(posedge spi_cs_n) sess = 0;
  always @(posedge spi_sclk) begin
    if (sess < 2 && !spi_mosi) mosi_bad++;
    if (sess >= 2 && spi_mosi) mosi_bad++;
    sess++;
    rises++;
  end
  always_comb begin
    if (sess < 8) spi_miso = sess[0];
    else spi_miso = img((sess - 8) / 8)[7 - ((sess - 8) % 8)];
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_valid = 1'b0; rd_fetch = 1'b0;
    repeat (4) @(negedge clk);
    rises = 0;
    mosi_bad = 0;
    rst_n = 1'b1;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d, output int lat);
    rd_addr = a; rd_fetch = 1'b0; rd_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rd_ready && lat < 300);
    d = rd_data;
    chk("R7 drive with ready", int'(rd_drive), 1);
    @(negedge clk);
    rd_valid = 1'b0;
    #0.5;
    chk("R7 drive released", int'(rd_drive), 0);
    chk("R7 data zero", int'(rd_data), 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sclk", int'(spi_sclk), 0);
    chk("R1 ready", int'(rd_ready), 0);
    chk("R1 drive", int'(rd_drive), 0);
    chk("R1 data", int'(rd_data), 0);
  endtask

  task automatic t_preamble();
    do_reset();
    repeat (30) @(negedge clk);
    chk("R2 preamble clocks", rises, 8);
    chk("R2 mosi pattern errors", mosi_bad, 0);
    chk("R2 cs_n low", int'(spi_cs_n), 0);
    repeat (20) @(negedge clk);
    chk("R3 no clocks while idle", rises, 8);
  endtask

  task automatic t_vector();
    logic [7:0] d; int lat;
    do_read(16'hFFFC, d, lat);
    chk("R4 vector low byte", int'(d), int'(img(0)));
    chk("R5 latency from idle", lat, 17);
    chk("R4 eight clocks per byte", rises, 16);
    do_read(16'hFFFD, d, lat);
    chk("R4 vector high byte", int'(d), int'(img(1)));
    chk("R5 latency second", lat, 17);
  endtask

  task automatic t_any_addr();
    logic [7:0] d; int lat;
    logic [15:0] addrs [4] = '{16'h8000, 16'hC123, 16'h8000, 16'hFFFF};
    foreach (addrs[k]) begin
      do_read(addrs[k], d, lat);
      chk("R6 sequential byte", int'(d), int'(img(2 + k)));
    end
    chk("R4 clocks after six bytes", rises, 8 + 6 * 8);
  endtask

  task automatic t_ram_data_read();
    logic [7:0] d; int lat; int seen = 0;
    rd_addr = 16'h0300; rd_fetch = 1'b0; rd_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rd_ready || rd_drive) seen++;
    end
    rd_valid = 1'b0;
    chk("R8 no response below window", seen, 0);
    chk("R8 no clocks", rises, 56);
    chk("R8 still selected", int'(spi_cs_n), 0);
    do_read(16'h9000, d, lat);
    chk("R8 stream continues", int'(d), int'(img(6)));
  endtask

  task automatic t_runtime();
    logic [7:0] d; int seen = 0; int r0;
    r0 = rises;
    @(negedge clk);
    rd_addr = 16'h0200; rd_fetch = 1'b1; rd_valid = 1'b1;
    @(negedge clk);
    chk("R9 cs_n released", int'(spi_cs_n), 1);
    chk("R9 no ready on ram fetch", int'(rd_ready), 0);
    rd_valid = 1'b0; rd_fetch = 1'b0;
    @(negedge clk);
    rd_addr = 16'h8000; rd_valid = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rd_ready || rd_drive || !spi_cs_n) seen++;
    end
    rd_valid = 1'b0;
    chk("R9 silent in runtime", seen, 0);
    chk("R9 no clocks in runtime", rises, r0);
    d = rd_data;
    chk("R9 data zero", int'(d), 0);
  endtask

  task automatic t_restart();
    logic [7:0] d; int lat;
    do_reset();
    repeat (40) @(negedge clk);
    do_read(16'hFFFC, d, lat);
    chk("R10 restart byte 0", int'(d), int'(img(0)));
    do_read(16'hFFFD, d, lat);
    chk("R10 restart byte 1", int'(d), int'(img(1)));
  endtask

  task automatic t_overlap();
    logic [7:0] d; int lat;
    do_reset();
    do_read(16'hFFFC, d, lat);
    chk("R11 byte 0 after waiting", int'(d), int'(img(0)));
    chk("R11 preamble plus one byte", rises, 16);
    chk("R11 mosi pattern", mosi_bad, 0);
    do_read(16'hFFFD, d, lat);
    chk("R11 byte 1", int'(d), int'(img(1)));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_preamble();
    t_vector();
    t_any_addr();
    t_ram_data_read();
    t_runtime();
    t_restart();
    t_overlap();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule